// File: doc/BRIEF.md
# Start-of-Frame Reference Pulse Tracker

This block turns the start-of-frame (SOF) notifications of a full-speed USB device into a timing reference for trimming its 48 MHz clock. Each time the protocol engine reports a received SOF, the tracker emits a one-cycle reference pulse. It also drives a qualifier that tells the trimming loop whether the pulse train can be trusted. The host sends an SOF once per millisecond, which is 48,000 cycles of the local clock. The tracker times the gap after every accepted SOF. If the gap exceeds the nominal frame plus a tolerance window, it withdraws the qualifier.

A disable control silences both outputs. The oscillator test mode, during which the device transmits a fixed pattern and cannot receive frames, does the same. A link that is not active drops the qualifier and is not trusted to deliver frames. Once the qualifier has fallen for any reason, it returns only with a freshly accepted SOF. The frame length and the tolerance are parameters, so a bench can run the block with a short frame.

Top module: `sof_ref_tracker`

## Requirements
- R1: A synchronous active-high reset clears both outputs and the gap timer. Both outputs read 0 on the cycle after a reset edge.
- R2: An SOF strobe sampled high is accepted when the link is active, disable is low and test mode is low. Each accepted strobe drives `ref_pulse_o` high for exactly the following cycle, so back-to-back strobes give back-to-back pulses.
- R3: After reset, `ref_valid_o` stays low until the first accepted SOF. It rises in the same cycle as that SOF's pulse, and it never rises without a pulse.
- R4: The window is LIMIT = FRAME_CYCLES + SLACK_CYCLES. Count clock edges j after the edge that accepted an SOF. With no further accepted SOF, `ref_valid_o` is 1 after edges j < LIMIT and 0 from edge j = LIMIT on. An SOF accepted at any j ≤ LIMIT keeps it high without a gap.
- R5: Once `ref_valid_o` has fallen, it stays low, however long the silence lasts, until the cycle of the next reference pulse.
- R6: While `ref_disable_i` is sampled high, both outputs read 0 on the following cycle. Strobes sampled during that time produce no pulse.
- R7: After `ref_disable_i` returns low, pulses resume with the next accepted SOF. `ref_valid_o` stays low until that SOF.
- R8: While `osc_test_i` is sampled high, strobes are ignored and both outputs read 0 on the following cycle.
- R9: A low `link_active_i` forces `ref_valid_o` to 0 on the following cycle, and strobes sampled meanwhile produce no pulse.
- R10: The gap timer saturates at LIMIT. An arbitrarily long silence never wraps it into a state that restores the qualifier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 48 MHz domain clock |
| rst | input | 1 | Synchronous active-high reset |
| sof_strobe_i | input | 1 | One-cycle notice that an SOF packet was received |
| link_active_i | input | 1 | Link is in an active state |
| ref_disable_i | input | 1 | Forces both reference outputs low |
| osc_test_i | input | 1 | Oscillator test mode; frame reception suspended |
| ref_pulse_o | output | 1 | One-cycle reference pulse per accepted SOF |
| ref_valid_o | output | 1 | Reference pulses are trustworthy |

## Verification
The embedded assertions watch every cycle for four properties. Disable, test mode and an inactive link always silence the outputs on the next cycle. A pulse is never emitted while the qualifier is low. The qualifier never rises without a pulse. A timer expiry always clears the qualifier, and the timer never runs past its window. The exact edge at which the qualifier falls for each SOF spacing can only be shown by the bench, and so can the recovery after a dropout. The bench sweeps every spacing from one cycle to beyond the window on a short frame, with the expected level worked out from the edge count. It also checks that silence does not restore the qualifier and that disable and test mode behave as described.

// File: rtl/sof_ref_pkg.sv
package sof_ref_pkg;

   // Qualified events leaving the input gate
   typedef struct packed {
      logic accept;   // strobe counts as a real SOF
      logic squash;   // conditions that forbid a trusted reference
   } sof_gate_t;

   function automatic int gap_width(input int limit);
      return $clog2(limit + 1);
   endfunction

endpackage

// File: rtl/sof_accept_gate.sv
module sof_accept_gate #(
   parameter bit LINK_GATES = 1'b1
) (
   input  logic                  sof_strobe_i,
   input  logic                  link_active_i,
   input  logic                  ref_disable_i,
   input  logic                  osc_test_i,
   output sof_ref_pkg::sof_gate_t gate_o
);

   logic link_ok;

   generate
      if (LINK_GATES) begin : g_link_gates
         assign link_ok = link_active_i;
      end else begin : g_link_ignored
         logic unused_link;
         assign unused_link = link_active_i;
         assign link_ok     = 1'b1;
      end
   endgenerate

   always_comb begin
      gate_o.squash = ref_disable_i | osc_test_i | ~link_ok;
      gate_o.accept = sof_strobe_i & ~gate_o.squash;
   end

endmodule

// File: rtl/sof_gap_timer.sv
module sof_gap_timer #(
   parameter int LIMIT = 49600,
   parameter int CW    = sof_ref_pkg::gap_width(LIMIT)
) (
   input  logic clk,
   input  logic rst,
   input  logic restart_i,
   input  logic squash_i,
   output logic expire_o
);

   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
   localparam logic [CW-1:0] TOP  = CW'(LIMIT);

   logic [CW-1:0] gap_q;
   logic          armed_q;

   initial begin
      if (LIMIT < 2) $error("sof_gap_timer: LIMIT must be at least 2");
      if ((1 << CW) <= LIMIT) $error("sof_gap_timer: CW too narrow");
   end

   assign expire_o = armed_q & (gap_q == LAST) & ~restart_i & ~squash_i;

   always_ff @(posedge clk) begin
      if (rst || squash_i) begin
         gap_q   <= '0;
         armed_q <= 1'b0;
      end else if (restart_i) begin
         gap_q   <= '0;
         armed_q <= 1'b1;
      end else begin
         if (gap_q != TOP) gap_q <= gap_q + 1'b1;
         if (expire_o) armed_q <= 1'b0;
      end
   end

   // R10: the timer saturates and never passes its window
   a_r10_gap_saturates: assert property (@(posedge clk) disable iff (rst)
      gap_q <= TOP);

   // R10: an expiry disarms the timer
   a_r10_expiry_disarms: assert property (@(posedge clk) disable iff (rst)
      expire_o |=> !armed_q);

endmodule

// File: rtl/sof_ref_qual.sv
module sof_ref_qual (
   input  logic                   clk,
   input  logic                   rst,
   input  sof_ref_pkg::sof_gate_t gate_i,
   input  logic                   expire_i,
   output logic                   pulse_o,
   output logic                   valid_o
);

   logic pulse_q;
   logic valid_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         pulse_q <= 1'b0;
         valid_q <= 1'b0;
      end else begin
         pulse_q <= gate_i.accept;
         if (gate_i.squash || expire_i) valid_q <= 1'b0;
         else if (gate_i.accept)        valid_q <= 1'b1;
      end
   end

   assign pulse_o = pulse_q;
   assign valid_o = valid_q;

endmodule

// File: rtl/sof_ref_tracker.sv
module sof_ref_tracker #(
   parameter int FRAME_CYCLES = 48000,
   parameter int SLACK_CYCLES = 1600,
   parameter bit LINK_GATES   = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic sof_strobe_i,
   input  logic link_active_i,
   input  logic ref_disable_i,
   input  logic osc_test_i,
   output logic ref_pulse_o,
   output logic ref_valid_o
);

   localparam int LIMIT = FRAME_CYCLES + SLACK_CYCLES;
   localparam int CW    = sof_ref_pkg::gap_width(LIMIT);

   sof_ref_pkg::sof_gate_t gate;
   logic                   expire;

   initial begin
      if (FRAME_CYCLES < 2) $error("sof_ref_tracker: FRAME_CYCLES too small");
      if (SLACK_CYCLES < 0 || SLACK_CYCLES >= FRAME_CYCLES)
         $error("sof_ref_tracker: SLACK_CYCLES out of range");
   end

   sof_accept_gate #(.LINK_GATES(LINK_GATES)) u_gate (
      .sof_strobe_i (sof_strobe_i),
      .link_active_i(link_active_i),
      .ref_disable_i(ref_disable_i),
      .osc_test_i   (osc_test_i),
      .gate_o       (gate)
   );

   sof_gap_timer #(.LIMIT(LIMIT), .CW(CW)) u_timer (
      .clk      (clk),
      .rst      (rst),
      .restart_i(gate.accept),
      .squash_i (gate.squash),
      .expire_o (expire)
   );

   sof_ref_qual u_qual (
      .clk     (clk),
      .rst     (rst),
      .gate_i  (gate),
      .expire_i(expire),
      .pulse_o (ref_pulse_o),
      .valid_o (ref_valid_o)
   );

   // R6: disable silences both outputs on the next cycle
   a_r6_disable_quiet: assert property (@(posedge clk) disable iff (rst)
      ref_disable_i |=> (!ref_pulse_o && !ref_valid_o));

   // R8: test mode silences both outputs on the next cycle
   a_r8_osc_quiet: assert property (@(posedge clk) disable iff (rst)
      osc_test_i |=> (!ref_pulse_o && !ref_valid_o));

   // R9: an inactive link clears the qualifier
   a_r9_link_drop: assert property (@(posedge clk) disable iff (rst)
      !link_active_i |=> !ref_valid_o);

   // R3: the qualifier only rises together with a pulse
   a_r3_rise_with_pulse: assert property (@(posedge clk) disable iff (rst)
      $rose(ref_valid_o) |-> ref_pulse_o);

   // R2: every pulse is a trusted one
   a_r2_pulse_is_valid: assert property (@(posedge clk) disable iff (rst)
      ref_pulse_o |-> ref_valid_o);

   // R4: a timer expiry withdraws the qualifier
   a_r4_expiry_drops: assert property (@(posedge clk) disable iff (rst)
      expire |=> !ref_valid_o);

endmodule

// File: tb/sof_ref_tracker_test.sv
module sof_ref_tracker_test;

   localparam int FRAME = 20;
   localparam int SLACK = 4;
   localparam int LIMIT = FRAME + SLACK;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic sof = 1'b0;
   logic link = 1'b1;
   logic dis = 1'b0;
   logic osc = 1'b0;
   logic pulse, valid;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   sof_ref_tracker #(.FRAME_CYCLES(FRAME), .SLACK_CYCLES(SLACK)) uut (
      .clk(clk), .rst(rst), .sof_strobe_i(sof), .link_active_i(link),
      .ref_disable_i(dis), .osc_test_i(osc),
      .ref_pulse_o(pulse), .ref_valid_o(valid)
   );

   task automatic step(input logic s);
      @(negedge clk);
      sof = s;
      @(posedge clk);
      #1;
   endtask

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      finish_run();
   end

   initial begin
      step(0); step(0);
      check("R1 pulse after reset", pulse, 1'b0);
      check("R1 valid after reset", valid, 1'b0);
      rst = 1'b0;

      for (int i = 0; i < 5; i++) begin
         step(0);
         check("R3 valid before first SOF", valid, 1'b0);
      end

      step(1);
      check("R2 first pulse", pulse, 1'b1);
      check("R3 valid with first pulse", valid, 1'b1);

      // spacing sweep: SOF gap of d edges
      for (int d = 1; d <= LIMIT + 3; d++) begin
         for (int j = 1; j < d; j++) begin
            step(0);
            check("R2 no pulse between SOFs", pulse, 1'b0);
            check((j < LIMIT) ? "R4 valid inside window" : "R5 valid stays low",
                  valid, (j < LIMIT));
         end
         step(1);
         check("R2 pulse on SOF", pulse, 1'b1);
         check("R4 valid with pulse", valid, 1'b1);
      end
      step(0);
      check("R2 pulse lasts one cycle", pulse, 1'b0);

      // R10: long silence never restores the qualifier
      for (int j = 0; j < 4 * LIMIT; j++) step(0);
      check("R10 valid after long silence", valid, 1'b0);
      check("R10 no pulse after long silence", pulse, 1'b0);

      // R6 / R7: disable
      step(1);
      check("R7 valid before disable", valid, 1'b1);
      dis = 1'b1;
      step(1);
      check("R6 pulse while disabled", pulse, 1'b0);
      check("R6 valid while disabled", valid, 1'b0);
      step(1);
      check("R6 pulse while disabled again", pulse, 1'b0);
      dis = 1'b0;
      for (int j = 0; j < 3; j++) begin
         step(0);
         check("R7 valid waits for SOF", valid, 1'b0);
      end
      step(1);
      check("R7 pulse after re-enable", pulse, 1'b1);
      check("R7 valid after re-enable", valid, 1'b1);

      // R8: oscillator test mode
      osc = 1'b1;
      step(1);
      check("R8 pulse in test mode", pulse, 1'b0);
      check("R8 valid in test mode", valid, 1'b0);
      step(1);
      check("R8 pulse in test mode again", pulse, 1'b0);
      osc = 1'b0;
      step(0);
      check("R8 valid after test mode", valid, 1'b0);

      // R9: link inactive
      step(1);
      check("R9 valid before link drop", valid, 1'b1);
      link = 1'b0;
      step(0);
      check("R9 valid on link drop", valid, 1'b0);
      step(1);
      check("R9 pulse while link down", pulse, 1'b0);
      link = 1'b1;
      step(1);
      check("R9 pulse after link returns", pulse, 1'b1);

      // R1: reset in mid-run
      rst = 1'b1;
      step(1);
      check("R1 pulse cleared by reset", pulse, 1'b0);
      check("R1 valid cleared by reset", valid, 1'b0);
      rst = 1'b0;
      step(0);
      check("R1 valid stays low after reset", valid, 1'b0);

      finish_run();
   end

endmodule